// File: doc/BRIEF.md
# Interrupt-to-DMA Request Router

This block stands between a bank of peripheral interrupt sources and two consumers: a DMA controller and an interrupt controller. Every source has a pending flag. A request pulse sets the flag, and the flag stays set until something clears it. The router then sends each pending flag to exactly one consumer. It can raise a transfer trigger on a DMA channel, or it can present the flag to the interrupt controller as an ordinary interrupt line.

The routing depends on a global DMA enable and on sixteen channels, each with an enable bit and a source index. A source is withheld from the interrupt controller when the global enable is set and at least one enabled channel names that source. If several enabled channels name the same source, the lowest-numbered channel takes it.

The DMA side acknowledges a transfer with a one-cycle pulse, and that pulse clears the source's flag. Software can clear only the flags of sources that are not routed to the DMA controller. All configuration sits in a small register file on a single-cycle write/read bus. Each write changes the routing from the next clock edge.

Top module: `irq_dma_router`

## Requirements
- R1: Synchronous reset clears the global enable, every channel enable, every channel index and every pending flag. After reset, irq_o, dma_trig_o and every register read are zero.
- R2: A one-cycle pulse on src_req_i[s] sets flag s from the next cycle, and the flag stays set until it is cleared. Flag s reads back at address 32 + s/32, bit s%32.
- R3: While the global enable (address 0, bit 0) is clear, irq_o equals the pending flags and dma_trig_o is zero.
- R4: While the global enable is set, source s is routed to DMA when some channel n has its enable set (address 1, bit n) and its index (address 2+n, bits 5:0) equal to s. A routed source never shows on irq_o. dma_trig_o[n] is high while channel n owns a pending routed source. Pending sources that no enabled channel names appear on irq_o.
- R5: When several enabled channels name one source, only the lowest-numbered of them raises its trigger, and the source stays off irq_o.
- R6: A pulse on dma_ack_i[n] clears the flag of channel n's source from the next cycle, but only while dma_trig_o[n] is high. An acknowledge on a channel whose trigger is low has no effect.
- R7: A write to address 32+w clears, for each bit set in the write data, the flag of source 32w+bit. Bits for sources that are currently routed to DMA are ignored.
- R8: When a request and a clear for the same source land in the same cycle, the request wins and the flag stays set.
- R9: A configuration write changes the routing from the next cycle onward, and the written value reads back at its address.
- R10: For every channel, a raised dma_trig_o[n] and a raised irq_o bit for the same source never occur in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| src_req_i | input | NUM_SRC | Request pulses, one per source |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register address for read and write |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i, combinational |
| dma_ack_i | input | NUM_CH | One-cycle acknowledge per DMA channel |
| dma_trig_o | output | NUM_CH | Transfer trigger per DMA channel |
| irq_o | output | NUM_SRC | Pending flags passed to the interrupt controller |

## Verification
The assertions assume a few things about the inputs. Acknowledges are one-cycle pulses. Register writes use only the addresses listed in the requirements. Reset is held for at least one clock edge before any request.

The stimulus keeps to these limits. It raises every input for exactly one cycle and then drops it. It writes only to the control, enable, index and flag-clear addresses. It releases reset only after several clock edges.

Within those limits, the properties still cover the awkward cases. These include a request arriving in the same cycle as a clear, two channels naming one source, and an acknowledge sent to a channel whose trigger is low.

// File: rtl/irq_dma_pkg.sv
package irq_dma_pkg;
    localparam int WORD_W = 32;
    // register addresses; flag words start at A_FLAG0
    localparam int A_CTRL  = 0;
    localparam int A_CHEN  = 1;
    localparam int A_SEL0  = 2;
    localparam int A_FLAG0 = 32;
    typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/idr_cfg_regs.sv
module idr_cfg_regs
    import irq_dma_pkg::*;
#(
    parameter int NUM_CH = 16,
    parameter int SEL_W  = 6,
    parameter int ADDR_W = 6,
    parameter int CFG_W  = 16
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            we_i,
    input  logic [ADDR_W-1:0]               addr_i,
    input  logic [CFG_W-1:0]                wdata_i,
    output logic                            me_o,
    output logic [NUM_CH-1:0]               chen_o,
    output logic [NUM_CH-1:0][SEL_W-1:0]    sel_o
);
    typedef struct packed {
        logic                         me;
        logic [NUM_CH-1:0]            chen;
        logic [NUM_CH-1:0][SEL_W-1:0] sel;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (we_i) begin
            if (addr_i == ADDR_W'(A_CTRL)) cfg_d.me = wdata_i[0];
            if (addr_i == ADDR_W'(A_CHEN)) cfg_d.chen = wdata_i[NUM_CH-1:0];
            for (int n = 0; n < NUM_CH; n++) begin
                if (addr_i == ADDR_W'(A_SEL0 + n)) cfg_d.sel[n] = wdata_i[SEL_W-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cfg_q <= '0;
        else     cfg_q <= cfg_d;
    end

    assign me_o   = cfg_q.me;
    assign chen_o = cfg_q.chen;
    assign sel_o  = cfg_q.sel;

    assert_me_write_R9: assert property (@(posedge clk) disable iff (rst)
        (we_i && addr_i == ADDR_W'(A_CTRL)) |=> (me_o == $past(wdata_i[0])));

    assert_chen_write_R9: assert property (@(posedge clk) disable iff (rst)
        (we_i && addr_i == ADDR_W'(A_CHEN)) |=> (chen_o == $past(wdata_i[NUM_CH-1:0])));

    assert_cfg_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !we_i |=> ($stable(me_o) && $stable(chen_o) && $stable(sel_o)));
endmodule

// File: rtl/idr_flags.sv
module idr_flags #(
    parameter int NUM_SRC = 64
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] set_i,
    input  logic [NUM_SRC-1:0] clr_i,
    output logic [NUM_SRC-1:0] flag_o
);
    typedef struct packed {
        logic [NUM_SRC-1:0] pend;
    } flag_state_t;

    flag_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // a set in the same cycle as a clear leaves the flag set
        st_d.pend = (st_q.pend & ~clr_i) | set_i;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign flag_o = st_q.pend;

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_chk
        assert_set_R2: assert property (@(posedge clk) disable iff (rst)
            set_i[s] |=> flag_o[s]);
        assert_set_wins_R8: assert property (@(posedge clk) disable iff (rst)
            (set_i[s] && clr_i[s]) |=> flag_o[s]);
        assert_clear_R6: assert property (@(posedge clk) disable iff (rst)
            (clr_i[s] && !set_i[s]) |=> !flag_o[s]);
        assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
            (!set_i[s] && !clr_i[s]) |=> (flag_o[s] == $past(flag_o[s])));
    end
endmodule

// File: rtl/idr_route.sv
module idr_route #(
    parameter int NUM_SRC = 64,
    parameter int NUM_CH  = 16,
    parameter int SEL_W   = 6
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         me_i,
    input  logic [NUM_CH-1:0]            chen_i,
    input  logic [NUM_CH-1:0][SEL_W-1:0] sel_i,
    input  logic [NUM_SRC-1:0]           flag_i,
    input  logic [NUM_CH-1:0]            ack_i,
    output logic [NUM_SRC-1:0]           mask_o,
    output logic [NUM_CH-1:0]            trig_o,
    output logic [NUM_SRC-1:0]           ack_clr_o
);
    // per-source mask: OR over enabled channels naming the source
    always_comb begin
        mask_o = '0;
        for (int n = 0; n < NUM_CH; n++) begin
            if (me_i && chen_i[n]) mask_o[sel_i[n]] = 1'b1;
        end
    end

    // a channel owns its source unless a lower enabled channel names it too
    for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
        logic shadowed;
        always_comb begin
            shadowed = 1'b0;
            for (int m = 0; m < n; m++) begin
                if (chen_i[m] && (sel_i[m] == sel_i[n])) shadowed = 1'b1;
            end
        end
        assign trig_o[n] = me_i && chen_i[n] && !shadowed && flag_i[sel_i[n]];

        assert_trig_masked_R4: assert property (@(posedge clk) disable iff (rst)
            trig_o[n] |-> (mask_o[sel_i[n]] && flag_i[sel_i[n]]));

        if (n > 0) begin : g_prio
            assert_low_wins_R5: assert property (@(posedge clk) disable iff (rst)
                trig_o[n] |-> !(trig_o[n-1] && (sel_i[n-1] == sel_i[n])));
        end
    end

    // acknowledge counts only on a channel that currently holds a trigger
    always_comb begin
        ack_clr_o = '0;
        for (int n = 0; n < NUM_CH; n++) begin
            if (ack_i[n] && trig_o[n]) ack_clr_o[sel_i[n]] = 1'b1;
        end
    end

    assert_me_off_R3: assert property (@(posedge clk) disable iff (rst)
        !me_i |-> (trig_o == '0 && mask_o == '0));
endmodule

// File: rtl/irq_dma_router.sv
module irq_dma_router
    import irq_dma_pkg::*;
#(
    parameter int NUM_SRC = 64,
    parameter int NUM_CH  = 16,
    parameter int ADDR_W  = 6
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] src_req_i,
    input  logic               reg_we_i,
    input  logic [ADDR_W-1:0]  reg_addr_i,
    input  logic [WORD_W-1:0]  reg_wdata_i,
    output logic [WORD_W-1:0]  reg_rdata_o,
    input  logic [NUM_CH-1:0]  dma_ack_i,
    output logic [NUM_CH-1:0]  dma_trig_o,
    output logic [NUM_SRC-1:0] irq_o
);
    localparam int SEL_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
    localparam int CFG_W   = (NUM_CH > SEL_W) ? NUM_CH : SEL_W;
    localparam int N_WORDS = (NUM_SRC + WORD_W - 1) / WORD_W;
    localparam int PAD_W   = N_WORDS * WORD_W;

    logic                         me;
    logic [NUM_CH-1:0]            chen;
    logic [NUM_CH-1:0][SEL_W-1:0] sel;
    logic [NUM_SRC-1:0]           flags, mask, ack_clr, sw_clr;
    logic [PAD_W-1:0]             flag_pad, mask_pad, clr_pad;

    idr_cfg_regs #(
        .NUM_CH(NUM_CH), .SEL_W(SEL_W), .ADDR_W(ADDR_W), .CFG_W(CFG_W)
    ) u_cfg (
        .clk(clk), .rst(rst), .we_i(reg_we_i), .addr_i(reg_addr_i),
        .wdata_i(reg_wdata_i[CFG_W-1:0]),
        .me_o(me), .chen_o(chen), .sel_o(sel)
    );

    idr_flags #(.NUM_SRC(NUM_SRC)) u_flags (
        .clk(clk), .rst(rst), .set_i(src_req_i), .clr_i(ack_clr | sw_clr),
        .flag_o(flags)
    );

    idr_route #(
        .NUM_SRC(NUM_SRC), .NUM_CH(NUM_CH), .SEL_W(SEL_W)
    ) u_route (
        .clk(clk), .rst(rst), .me_i(me), .chen_i(chen), .sel_i(sel),
        .flag_i(flags), .ack_i(dma_ack_i),
        .mask_o(mask), .trig_o(dma_trig_o), .ack_clr_o(ack_clr)
    );

    assign flag_pad = PAD_W'(flags);
    assign mask_pad = PAD_W'(mask);

    // software clear, suppressed for DMA-routed sources
    always_comb begin
        clr_pad = '0;
        for (int w = 0; w < N_WORDS; w++) begin
            if (reg_we_i && reg_addr_i == ADDR_W'(A_FLAG0 + w))
                clr_pad[w*WORD_W +: WORD_W] = reg_wdata_i & ~mask_pad[w*WORD_W +: WORD_W];
        end
    end
    assign sw_clr = clr_pad[NUM_SRC-1:0];

    always_comb begin
        reg_rdata_o = '0;
        if (reg_addr_i == ADDR_W'(A_CTRL)) reg_rdata_o[0] = me;
        if (reg_addr_i == ADDR_W'(A_CHEN)) reg_rdata_o[NUM_CH-1:0] = chen;
        for (int n = 0; n < NUM_CH; n++) begin
            if (reg_addr_i == ADDR_W'(A_SEL0 + n)) reg_rdata_o[SEL_W-1:0] = sel[n];
        end
        for (int w = 0; w < N_WORDS; w++) begin
            if (reg_addr_i == ADDR_W'(A_FLAG0 + w)) reg_rdata_o = flag_pad[w*WORD_W +: WORD_W];
        end
    end

    assign irq_o = flags & ~mask;

    for (genvar n = 0; n < NUM_CH; n++) begin : g_excl
        assert_exclusive_R10: assert property (@(posedge clk) disable iff (rst)
            dma_trig_o[n] |-> !irq_o[sel[n]]);
    end

    assert_passthru_R3: assert property (@(posedge clk) disable iff (rst)
        !me |-> (irq_o == flags && dma_trig_o == '0));
endmodule

// File: tb/irq_dma_router_bench.sv
module irq_dma_router_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] src_req = '0;
    logic        we = 1'b0;
    logic [5:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [15:0] ack = '0;
    logic [15:0] trig;
    logic [63:0] irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    irq_dma_router u_irq_dma_router (
        .clk(clk), .rst(rst), .src_req_i(src_req), .reg_we_i(we),
        .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
        .dma_ack_i(ack), .dma_trig_o(trig), .irq_o(irq)
    );

    typedef struct packed {
        logic        we;
        logic [5:0]  addr;
        logic [31:0] wdata;
        logic [63:0] req;
        logic [15:0] ack;
        logic [63:0] exp_irq;
        logic [15:0] exp_trig;
    } vec_t;

    localparam vec_t VECS [15] = '{
        '{1'b1, 6'd0,  32'h1,        64'h0,                  16'h0, 64'h0,                  16'h0}, // R9 enable on
        '{1'b1, 6'd1,  32'h3,        64'h0,                  16'h0, 64'h0,                  16'h0}, // R9 ch0,ch1
        '{1'b1, 6'd2,  32'd5,        64'h0,                  16'h0, 64'h0,                  16'h0}, // R9 ch0 -> 5
        '{1'b1, 6'd3,  32'd5,        64'h0,                  16'h0, 64'h0,                  16'h0}, // R9 ch1 -> 5
        '{1'b0, 6'd0,  32'h0,        64'h220,                16'h0, 64'h200,                16'h1}, // R5 R10
        '{1'b0, 6'd0,  32'h0,        64'h0,                  16'h2, 64'h200,                16'h1}, // R6 idle ack
        '{1'b0, 6'd0,  32'h0,        64'h0,                  16'h1, 64'h200,                16'h0}, // R6 ack
        '{1'b1, 6'd3,  32'd9,        64'h0,                  16'h0, 64'h0,                  16'h2}, // R9 ch1 -> 9
        '{1'b1, 6'd32, 32'h200,      64'h0,                  16'h0, 64'h0,                  16'h2}, // R7 ignored
        '{1'b1, 6'd0,  32'h0,        64'h0,                  16'h0, 64'h200,                16'h0}, // R3 enable off
        '{1'b1, 6'd32, 32'h200,      64'h0,                  16'h0, 64'h0,                  16'h0}, // R7 clear
        '{1'b0, 6'd0,  32'h0,        64'h8000000000000001,   16'h0, 64'h8000000000000001,   16'h0}, // R2
        '{1'b1, 6'd33, 32'h80000000, 64'h8000000000000000,   16'h0, 64'h8000000000000001,   16'h0}, // R8
        '{1'b1, 6'd32, 32'h1,        64'h0,                  16'h0, 64'h8000000000000000,   16'h0}, // R7 word 0
        '{1'b1, 6'd0,  32'h1,        64'h0,                  16'h0, 64'h8000000000000000,   16'h0}  // R4 unselected
    };

    function automatic string row_tag(input int i);
        case (i)
            0, 1, 2, 3, 7: return "R9";
            4:             return "R5/R10";
            5, 6:          return "R6";
            8, 10, 13:     return "R7";
            9:             return "R3";
            11:            return "R2";
            12:            return "R8";
            default:       return "R4";
        endcase
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic rd_check(input string tag, input logic [5:0] a, input logic [31:0] exp);
        @(negedge clk);
        addr = a;
        #1;
        check(tag, $sformatf("read addr %0d", a), {32'h0, rdata}, {32'h0, exp});
    endtask

    initial begin
        repeat (10000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1", "irq", irq, 64'h0);
        check("R1", "trig", {48'h0, trig}, 64'h0);
        rd_check("R1", 6'd0, 32'h0);
        rd_check("R1", 6'd1, 32'h0);
        rd_check("R1", 6'd32, 32'h0);

        for (int i = 0; i < 15; i++) begin
            @(negedge clk);
            we = VECS[i].we; addr = VECS[i].addr; wdata = VECS[i].wdata;
            src_req = VECS[i].req; ack = VECS[i].ack;
            @(negedge clk);
            we = 1'b0; src_req = '0; ack = '0; wdata = '0;
            #1;
            check(row_tag(i), $sformatf("row %0d irq", i), irq, VECS[i].exp_irq);
            check(row_tag(i), $sformatf("row %0d trig", i), {48'h0, trig}, {48'h0, VECS[i].exp_trig});
        end

        // R9 readback of configuration, R2 flag readback
        rd_check("R9", 6'd0, 32'h1);
        rd_check("R9", 6'd1, 32'h3);
        rd_check("R9", 6'd2, 32'd5);
        rd_check("R9", 6'd3, 32'd9);
        rd_check("R2", 6'd33, 32'h80000000);
        rd_check("R2", 6'd32, 32'h0);

        // R1 reset in mid-run
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        #1;
        check("R1", "irq after reset", irq, 64'h0);
        check("R1", "trig after reset", {48'h0, trig}, 64'h0);
        rd_check("R1", 6'd0, 32'h0);
        rd_check("R1", 6'd3, 32'h0);
        rd_check("R1", 6'd33, 32'h0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule